// File: doc/BRIEF.md
# Key-Gated Layer Result Selector

This block sits on the result stream between a multiply-accumulate engine and the layer that consumes its output. Every result beat carries the index of the layer it belongs to and the output address it was computed for. A per-chip layer key holds one bit for each layer. When that layer's bit is set, the true result goes through untouched. When the bit is clear, the block replaces the result with a decoy. The decoy comes from a fixed mixing function of the output address, the key word and the weight word supplied with the beat.

Decoys need no storage. For a given key and weight word, the same address always gives the same decoy, so a wrong key yields output that looks stable but is wrong. The key is loaded once after reset through an internal port and cannot be changed after that. An optional output register adds one cycle of latency. The latency is the same on both paths, so timing does not show which path was taken.

Top module: `lgs_top`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the key reads as all zeros until it is loaded, so every layer takes the decoy path.
- R2: For a layer index below 16 whose key bit (bit number = layer index) is 1, out_data equals the in_data of the same beat.
- R3: For a layer index below 16 whose key bit is 0, out_data equals the decoy value of R5.
- R4: A layer index of 16 or more always takes the decoy path, whatever the key.
- R5: The decoy is computed as follows. Let t = zero-extended 16-bit address XOR key. Then t ^= t<<7; t ^= t>>9; t = (t * 0x9E37) mod 2^16; t ^= weight word; t ^= t>>8. The decoy is t truncated to the result width. Equal address, key and weight give equal decoys.
- R6: With the output register enabled (the default), each accepted beat appears on the output exactly one cycle after acceptance, on both paths.
- R7: Each accepted input beat produces exactly one output beat, in order. in_ready is 1 whenever the output stage is empty or out_ready is 1. While out_valid is 1 and out_ready is 0, in_ready is 0 and the output beat holds steady.
- R8: out_layer and out_addr carry the layer index and address of the beat shown on out_data.
- R9: The first key_load pulse after reset captures key_value. Any later pulse is ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | One-shot key capture strobe |
| key_value | input | 16 | Layer key, bit n gates layer n |
| in_valid | input | 1 | Result beat present |
| in_ready | output | 1 | Block accepts the beat |
| in_layer | input | 5 | Layer index of the beat |
| in_addr | input | 10 | Output address of the beat |
| in_data | input | 16 | True accumulation result |
| in_wgt | input | 16 | Weight word mixed into the decoy |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_layer | output | 5 | Layer index of the output beat |
| out_addr | output | 10 | Address of the output beat |
| out_data | output | 16 | True result or decoy |

## Verification
The properties assume the source follows the usual valid/ready rules: once in_valid is raised, it stays high with a steady payload until in_ready takes the beat. The stall and latency properties compare the output with the input payload one cycle earlier, and they rely on this. The bench driver holds each beat until it sees in_ready and only then changes or drops it. It pulses key_load only after reset. The downstream side is stalled in a fixed repeating pattern, so hold cycles happen next to both real and decoy beats.

// File: rtl/lgs_pkg.sv
package lgs_pkg;

    localparam int KEY_BITS  = 16;
    localparam int KIDX_W    = $clog2(KEY_BITS);
    localparam int LAYER_W   = 5;
    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 16;
    localparam int WGT_W     = 16;
    localparam int MIX_W     = 16;
    localparam logic [MIX_W-1:0] MIX_MUL = 16'h9E37;
    localparam int MIX_SHL   = 7;
    localparam int MIX_SHR1  = 9;
    localparam int MIX_SHR2  = 8;

    typedef struct packed {
        logic [LAYER_W-1:0] layer;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
    } beat_t;

    typedef enum logic {
        SRC_DECOY = 1'b0,
        SRC_TRUE  = 1'b1
    } src_e;

    function automatic logic [MIX_W-1:0] mix_decoy(
        input logic [ADDR_W-1:0] addr,
        input logic [KEY_BITS-1:0] key,
        input logic [WGT_W-1:0] wgt
    );
        logic [MIX_W-1:0] t;
        t = MIX_W'(addr) ^ MIX_W'(key);
        t = t ^ (t << MIX_SHL);
        t = t ^ (t >> MIX_SHR1);
        t = MIX_W'(t * MIX_MUL);
        t = t ^ MIX_W'(wgt);
        t = t ^ (t >> MIX_SHR2);
        return t;
    endfunction

endpackage

// File: rtl/lgs_key_reg.sv
module lgs_key_reg
    import lgs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                key_load,
    input  logic [KEY_BITS-1:0] key_value,
    output logic [KEY_BITS-1:0] key_q
);
    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q    <= '0;
            locked_q <= 1'b0;
        end else if (key_load && !locked_q) begin
            key_q    <= key_value;
            locked_q <= 1'b1;
        end
    end

    p_key_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(key_q));
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q);
    p_unloaded_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !locked_q |-> key_q == '0);
endmodule

// File: rtl/lgs_decoy_gen.sv
module lgs_decoy_gen
    import lgs_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic [KEY_BITS-1:0] key,
    input  logic [WGT_W-1:0]    wgt,
    output logic [DATA_W-1:0]   decoy
);
    logic [MIX_W-1:0] mixed;

    always_comb mixed = mix_decoy(addr, key, wgt);

    generate
        if (DATA_W <= MIX_W) begin : g_trunc
            assign decoy = mixed[DATA_W-1:0];
        end else begin : g_ext
            assign decoy = DATA_W'(mixed);
        end
    endgenerate
endmodule

// File: rtl/lgs_out_stage.sv
module lgs_out_stage
    import lgs_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  s_valid,
    output logic  s_ready,
    input  beat_t s_beat,
    output logic  m_valid,
    input  logic  m_ready,
    output beat_t m_beat
);
    generate
        if (REG_OUT) begin : g_reg
            logic  vld_q;
            beat_t beat_q;

            assign s_ready = !vld_q || m_ready;
            assign m_valid = vld_q;
            assign m_beat  = beat_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q  <= 1'b0;
                    beat_q <= '0;
                end else if (s_ready) begin
                    vld_q <= s_valid;
                    if (s_valid) beat_q <= s_beat;
                end
            end

            p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
                (m_valid && !m_ready) |=> (m_valid && $stable(m_beat)));
            p_stall_block_r7: assert property (@(posedge clk) disable iff (rst)
                (m_valid && !m_ready) |-> !s_ready);
            p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
                (s_valid && s_ready) |=> (m_valid && m_beat == $past(s_beat)));
        end else begin : g_comb
            assign s_ready = m_ready;
            assign m_valid = s_valid;
            assign m_beat  = s_beat;
        end
    endgenerate
endmodule

// File: rtl/lgs_top.sv
module lgs_top
    import lgs_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                key_load,
    input  logic [KEY_BITS-1:0] key_value,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [LAYER_W-1:0]  in_layer,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [WGT_W-1:0]    in_wgt,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [LAYER_W-1:0]  out_layer,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [DATA_W-1:0]   out_data
);
    logic [KEY_BITS-1:0] key_q;
    logic [DATA_W-1:0]   decoy;
    logic                in_range;
    src_e                src;
    beat_t               sel_beat;
    beat_t               out_beat;

    lgs_key_reg i_key (
        .clk       (clk),
        .rst       (rst),
        .key_load  (key_load),
        .key_value (key_value),
        .key_q     (key_q)
    );

    lgs_decoy_gen i_decoy (
        .addr  (in_addr),
        .key   (key_q),
        .wgt   (in_wgt),
        .decoy (decoy)
    );

    always_comb begin
        in_range = (int'(in_layer) < KEY_BITS);
        src      = (in_range && key_q[in_layer[KIDX_W-1:0]]) ? SRC_TRUE : SRC_DECOY;
        sel_beat.layer = in_layer;
        sel_beat.addr  = in_addr;
        sel_beat.data  = (src == SRC_TRUE) ? in_data : decoy;
    end

    lgs_out_stage #(.REG_OUT(REG_OUT)) i_stage (
        .clk     (clk),
        .rst     (rst),
        .s_valid (in_valid),
        .s_ready (in_ready),
        .s_beat  (sel_beat),
        .m_valid (out_valid),
        .m_ready (out_ready),
        .m_beat  (out_beat)
    );

    assign out_layer = out_beat.layer;
    assign out_addr  = out_beat.addr;
    assign out_data  = out_beat.data;

    generate
        if (REG_OUT) begin : g_chk
            p_true_pass_r2: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_ready && src == SRC_TRUE) |=> out_data == $past(in_data));
            p_far_layer_r4: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_ready && !in_range) |=> out_data == $past(decoy));
            p_tags_r8: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_ready) |=> (out_addr == $past(in_addr) && out_layer == $past(in_layer)));
        end
    endgenerate

    p_ready_pass_r7: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);
endmodule

// File: tb/test_lgs_top.sv
`timescale 1ns/100ps
module test_lgs_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_load = 1'b0;
    logic [15:0] key_value = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  in_layer = '0;
    logic [9:0]  in_addr = '0;
    logic [15:0] in_data = '0;
    logic [15:0] in_wgt = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [4:0]  out_layer;
    logic [9:0]  out_addr;
    logic [15:0] out_data;

    always #2.5 clk = ~clk;

    lgs_top i_lgs_top (
        .clk(clk), .rst(rst), .key_load(key_load), .key_value(key_value),
        .in_valid(in_valid), .in_ready(in_ready), .in_layer(in_layer),
        .in_addr(in_addr), .in_data(in_data), .in_wgt(in_wgt),
        .out_valid(out_valid), .out_ready(out_ready), .out_layer(out_layer),
        .out_addr(out_addr), .out_data(out_data)
    );

    typedef struct {
        logic [15:0] d;
        logic [4:0]  l;
        logic [9:0]  a;
        int          acc;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic [15:0] key_model = '0;
    bit          key_taken = 0;
    bit          stall_mode = 0;
    bit          head_seen = 0;
    bit          mon_on = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // R5 mixing function, written from the requirement text
    function automatic logic [15:0] ref_decoy(input logic [9:0] a, input logic [15:0] k,
                                              input logic [15:0] w);
        logic [15:0] t;
        logic [31:0] p;
        t = {6'b0, a} ^ k;
        t = t ^ {t[8:0], 7'b0};
        t = t ^ {9'b0, t[15:9]};
        p = t * 32'h9E37;
        t = p[15:0] ^ w;
        t = t ^ {8'b0, t[15:8]};
        return t;
    endfunction

    task automatic load_key(input logic [15:0] k);
        @(negedge clk);
        key_value = k;
        key_load  = 1'b1;
        if (!key_taken) begin
            key_model = k;
            key_taken = 1;
        end
        @(negedge clk);
        key_load = 1'b0;
    endtask

    task automatic send(input logic [4:0] l, input logic [9:0] a, input logic [15:0] d,
                        input logic [15:0] w, input string req);
        exp_t e;
        bit   real_path;
        real_path = (l < 16) && key_model[l[3:0]];
        e.d   = real_path ? d : ref_decoy(a, key_model, w);
        e.l   = l;
        e.a   = a;
        e.req = req;
        @(negedge clk);
        in_valid = 1'b1;
        in_layer = l;
        in_addr  = a;
        in_data  = d;
        in_wgt   = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        e.acc = cyc;
        q.push_back(e);
        @(posedge clk);
        #0.5;
        in_valid = 1'b0;
    endtask

    // monitor and downstream ready
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
                #2;
                if (out_valid && !out_ready)
                    check(!in_ready, "R7", "in_ready during stall", in_ready, 0);
                if (out_valid) begin
                    if (q.size() == 0) begin
                        check(0, "R7", "output beat with nothing expected", out_data, 0);
                    end else begin
                        if (!head_seen) begin
                            check(cyc == q[0].acc + 1, "R6", "latency cycle", cyc, q[0].acc + 1);
                            head_seen = 1;
                        end
                        if (out_ready) begin
                            check(out_data == q[0].d, q[0].req, "out_data", out_data, q[0].d);
                            check(out_layer == q[0].l && out_addr == q[0].a, "R8", "tags",
                                  {out_layer, out_addr}, {q[0].l, q[0].a});
                            void'(q.pop_front());
                            head_seen = 0;
                        end
                    end
                end
            end
        end
    end

    initial begin
        #200000;
        check(0, "WDOG", "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
        mon_on = 1;

        // R1: unloaded key means decoys everywhere (R3 path with key zero)
        send(5'd0, 10'h001, 16'h1111, 16'h0000, "R1");
        send(5'd3, 10'h2AB, 16'h2222, 16'hBEEF, "R1");

        // R9: first load captures
        load_key(16'hA5C3);
        // R2: bits 0,1,6,7,8,10,13,15 are set
        send(5'd0, 10'h010, 16'hCAFE, 16'h1234, "R2");
        send(5'd1, 10'h3FF, 16'h0001, 16'h0000, "R2");
        send(5'd15, 10'h000, 16'hFFFF, 16'h5555, "R2");
        // R3: clear bits
        send(5'd2, 10'h010, 16'hCAFE, 16'h1234, "R3");
        send(5'd14, 10'h3FF, 16'h7777, 16'hFFFF, "R3");
        // R4: out-of-range layers
        send(5'd16, 10'h055, 16'h9999, 16'h0F0F, "R4");
        send(5'd31, 10'h100, 16'h8888, 16'hA0A0, "R4");
        // R5: same address, key, weight give same decoy regardless of data
        send(5'd4, 10'h123, 16'h0000, 16'h4242, "R5");
        send(5'd4, 10'h123, 16'hFFFF, 16'h4242, "R5");
        send(5'd20, 10'h123, 16'h3333, 16'h4242, "R5");

        // R9: later load ignored; layer 2 stays decoy, layer 0 stays true
        load_key(16'h0004);
        send(5'd2, 10'h077, 16'h4444, 16'h0101, "R9");
        send(5'd0, 10'h077, 16'h5555, 16'h0101, "R9");

        // R7: downstream stalls across mixed beats
        stall_mode = 1;
        for (int i = 0; i < 24; i++)
            send(5'(i), 10'(i * 37), 16'(i * 16'h1357), 16'(i * 16'h0B0B), "R7");
        // back-to-back traffic (driver re-raises valid next cycle)
        stall_mode = 0;
        for (int i = 0; i < 8; i++)
            send(5'(i + 6), 10'(i + 900), 16'(16'hF000 + i), 16'h00FF, "R6");

        for (int i = 0; i < 50 && q.size() != 0; i++) @(negedge clk);
        check(q.size() == 0, "R7", "beats left undelivered", q.size(), 0);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule